// File: doc/BRIEF.md
# Integer ALU with a Single Shared Adder

This block is the combinational arithmetic and logic unit of a RISC-V style integer core. It takes two operands and a 4-bit operation code and returns a result together with zero, negative, carry and overflow flags. The register-register instructions and their immediate variants both use it. The core only selects a different operand B for the immediate forms, so the ALU needs no knowledge of them.

Add, subtract and both set-less-than variants all pass through one adder/subtractor. Subtraction is done by inverting B and feeding a carry-in of one. The signed ordering is the sign of the difference XOR its overflow. The unsigned ordering is a borrow, which is a missing carry-out. Bitwise operations and shifts have their own small units. The branch unit can read the zero flag directly. Multiply, divide, program-counter increment and hazard comparison are done elsewhere.

Top module: `rv_alu_shared`

## Requirements
- R1: Code 0 (add) returns A+B modulo 2^WIDTH, and carry_o is the carry out of that sum.
- R2: Code 1 (subtract) returns A-B modulo 2^WIDTH. carry_o is 1 exactly when no borrow occurs (A >= B unsigned). ovf_o is 1 exactly when the signed difference does not fit in WIDTH bits.
- R3: Code 2 returns A AND B, code 3 returns A OR B, and code 4 returns A XOR B.
- R4: Code 5 (signed less-than) returns 1 when A < B as two's-complement numbers and 0 otherwise, with all upper bits zero.
- R5: Code 6 (unsigned less-than) returns 1 when A < B as unsigned numbers and 0 otherwise, with all upper bits zero.
- R6: Code 7 shifts A left by B[log2(WIDTH)-1:0] and fills with zeros. The upper bits of B have no effect.
- R7: Code 8 shifts A right logically by the same shift amount and fills with zeros.
- R8: Code 9 shifts A right arithmetically by the same shift amount and fills with copies of A's top bit.
- R9: Codes 10 to 15 return zero.
- R10: zero_o is 1 exactly when the result is all zeros, for every code.
- R11: neg_o equals the top bit of the result. For add, subtract and addition with overflow, ovf_o is 1 exactly when the signed sum does not fit in WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B (register value or immediate) |
| op_i | input | 4 | Operation code |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Top bit of result |
| carry_o | output | 1 | Carry out of the shared adder |
| ovf_o | output | 1 | Signed overflow of the shared adder |

## Verification
The bench builds two copies of the block. The first uses the default WIDTH of 32 and runs directed cases at the sign boundary, the carry boundary and the shift-amount boundary. The second uses WIDTH of 8, which makes every operand pair reachable. Subtraction, both less-than forms and their carry and overflow flags are checked over all 65,536 pairs. Every case in which a borrow, an overflow or a signed/unsigned disagreement could be decoded wrongly is therefore covered.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLTU = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_SUM,
        SEL_BITWISE,
        SEL_LT_S,
        SEL_LT_U,
        SEL_SHIFT,
        SEL_NONE
    } res_sel_e;

    typedef enum logic [1:0] {
        BW_AND,
        BW_OR,
        BW_XOR
    } bitwise_fn_e;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_RIGHT_LOG,
        SH_RIGHT_ARITH
    } shift_fn_e;

    typedef struct packed {
        logic        subtract;
        res_sel_e    sel;
        bitwise_fn_e bw_fn;
        shift_fn_e   sh_fn;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [3:0] code);
        alu_ctrl_t c;
        c.subtract = 1'b0;
        c.sel      = SEL_NONE;
        c.bw_fn    = BW_AND;
        c.sh_fn    = SH_LEFT;
        case (code)
            OP_ADD:  c.sel = SEL_SUM;
            OP_SUB:  begin c.sel = SEL_SUM;  c.subtract = 1'b1; end
            OP_AND:  begin c.sel = SEL_BITWISE; c.bw_fn = BW_AND; end
            OP_OR:   begin c.sel = SEL_BITWISE; c.bw_fn = BW_OR;  end
            OP_XOR:  begin c.sel = SEL_BITWISE; c.bw_fn = BW_XOR; end
            OP_SLT:  begin c.sel = SEL_LT_S; c.subtract = 1'b1; end
            OP_SLTU: begin c.sel = SEL_LT_U; c.subtract = 1'b1; end
            OP_SLL:  begin c.sel = SEL_SHIFT; c.sh_fn = SH_LEFT;        end
            OP_SRL:  begin c.sel = SEL_SHIFT; c.sh_fn = SH_RIGHT_LOG;   end
            OP_SRA:  begin c.sel = SEL_SHIFT; c.sh_fn = SH_RIGHT_ARITH; end
            default: c.sel = SEL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rv_alu_addsub.sv
module rv_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             subtract_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide_sum;

    // The only adder in the ALU; subtraction uses inverted B plus a carry-in
    assign b_eff    = subtract_i ? ~b_i : b_i;
    assign wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract_i};
    assign sum_o    = wide_sum[WIDTH-1:0];
    assign carry_o  = wide_sum[WIDTH];
    assign ovf_o    = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/rv_alu_bitwise.sv
module rv_alu_bitwise
    import rv_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  bitwise_fn_e      fn_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        case (fn_i)
            BW_OR:   y_o = a_i | b_i;
            BW_XOR:  y_o = a_i ^ b_i;
            default: y_o = a_i & b_i;
        endcase
    end
endmodule

// File: rtl/rv_alu_shifter.sv
module rv_alu_shifter
    import rv_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [SHW-1:0]   shamt_i,
    input  shift_fn_e        fn_i,
    output logic [WIDTH-1:0] y_o
);
    logic signed [WIDTH-1:0] a_signed;
    assign a_signed = a_i;

    always_comb begin
        case (fn_i)
            SH_RIGHT_LOG:   y_o = a_i >> shamt_i;
            SH_RIGHT_ARITH: y_o = a_signed >>> shamt_i;
            default:        y_o = a_i << shamt_i;
        endcase
    end
endmodule

// File: rtl/rv_alu_shared.sv
module rv_alu_shared
    import rv_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             neg_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int SHW = $clog2(WIDTH);
    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctl;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] bw_y;
    logic [WIDTH-1:0] sh_y;
    logic             add_carry;
    logic             add_ovf;
    logic             lt_signed;
    logic             lt_unsigned;

    assign ctl = decode_op(op_i);

    rv_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i        (a_i),
        .b_i        (b_i),
        .subtract_i (ctl.subtract),
        .sum_o      (sum),
        .carry_o    (add_carry),
        .ovf_o      (add_ovf)
    );

    rv_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i  (a_i),
        .b_i  (b_i),
        .fn_i (ctl.bw_fn),
        .y_o  (bw_y)
    );

    rv_alu_shifter #(.WIDTH(WIDTH)) u_shifter (
        .a_i     (a_i),
        .shamt_i (b_i[SHW-1:0]),
        .fn_i    (ctl.sh_fn),
        .y_o     (sh_y)
    );

    // Orderings derived from the single subtraction
    assign lt_signed   = sum[MSB] ^ add_ovf;
    assign lt_unsigned = ~add_carry;

    always_comb begin
        case (ctl.sel)
            SEL_SUM:     result_o = sum;
            SEL_BITWISE: result_o = bw_y;
            SEL_LT_S:    result_o = {{(WIDTH-1){1'b0}}, lt_signed};
            SEL_LT_U:    result_o = {{(WIDTH-1){1'b0}}, lt_unsigned};
            SEL_SHIFT:   result_o = sh_y;
            default:     result_o = '0;
        endcase
    end

    assign zero_o  = (result_o == '0);
    assign neg_o   = result_o[MSB];
    assign carry_o = add_carry;
    assign ovf_o   = add_ovf;
endmodule

// File: rtl/rv_alu_shared_chk.sv
module rv_alu_shared_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             neg_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] exp_add;
    logic             known;

    assign exp_add = a_i + b_i;
    assign known   = !$isunknown({a_i, b_i, op_i, result_o, zero_o, neg_o});

    always_comb begin
        if (known) begin
            if (op_i == 4'd0)
                assert_add_sum_R1: assert (result_o == exp_add)
                    else $error("add result mismatch");
            if (op_i == 4'd5)
                assert_slt_order_R4: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
                    else $error("signed less-than mismatch");
            if (op_i == 4'd6)
                assert_sltu_order_R5: assert (result_o == {{(WIDTH-1){1'b0}}, (a_i < b_i)})
                    else $error("unsigned less-than mismatch");
            if (op_i == 4'd9)
                assert_sra_sign_R8: assert (result_o[MSB] == a_i[MSB])
                    else $error("arithmetic shift lost sign");
            if (op_i >= 4'd10)
                assert_unused_zero_R9: assert (result_o == '0)
                    else $error("unused code gave nonzero result");
            assert_zero_flag_R10: assert (zero_o == (result_o == '0))
                else $error("zero flag disagrees with result");
            assert_neg_flag_R11: assert (neg_o == result_o[MSB])
                else $error("negative flag disagrees with result");
        end
    end
endmodule

bind rv_alu_shared rv_alu_shared_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .neg_o    (neg_o)
);

// File: tb/rv_alu_shared_tb.sv
module rv_alu_shared_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // 32-bit instance
    logic [31:0] a, b, res;
    logic [3:0]  op;
    logic        zf, nf, cf, vf;

    rv_alu_shared #(.WIDTH(32)) u_dut (
        .a_i(a), .b_i(b), .op_i(op),
        .result_o(res), .zero_o(zf), .neg_o(nf), .carry_o(cf), .ovf_o(vf)
    );

    // 8-bit instance for exhaustive sweeps
    logic [7:0] na, nb, nres;
    logic [3:0] nop;
    logic       nzf, nnf, ncf, nvf;

    rv_alu_shared #(.WIDTH(8)) u_narrow (
        .a_i(na), .b_i(nb), .op_i(nop),
        .result_o(nres), .zero_o(nzf), .neg_o(nnf), .carry_o(ncf), .ovf_o(nvf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref32(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        logic signed [31:0] xs;
        xs = x;
        case (o)
            4'd0: return x + y;
            4'd1: return x - y;
            4'd2: return x & y;
            4'd3: return x | y;
            4'd4: return x ^ y;
            4'd5: return {31'b0, ($signed(x) < $signed(y))};
            4'd6: return {31'b0, (x < y)};
            4'd7: return x << y[4:0];
            4'd8: return x >> y[4:0];
            4'd9: return xs >>> y[4:0];
            default: return 32'd0;
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        op = o; a = x; b = y;
        #2;
    endtask

    task automatic run_op(input string tag, input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        apply(o, x, y);
        chk(tag, res, ref32(o, x, y));
        chk({tag, " R10 zero"}, {31'b0, zf}, {31'b0, (ref32(o, x, y) == 32'd0)});
        chk({tag, " R11 neg"}, {31'b0, nf}, {31'b0, ref32(o, x, y) >> 31});
    endtask

    task automatic t_reset_state;
        apply(4'd0, 32'd0, 32'd0);
        chk("R1 idle result", res, 32'd0);
        chk("R10 idle zero", {31'b0, zf}, 32'd1);
    endtask

    task automatic t_add;
        logic [32:0] w;
        run_op("R1 add small", 4'd0, 32'd17, 32'd25);
        run_op("R1 add wrap", 4'd0, 32'hFFFF_FFFF, 32'd1);
        w = {1'b0, 32'hFFFF_FFFF} + 33'd1;
        chk("R1 add carry", {31'b0, cf}, {31'b0, w[32]});
        apply(4'd0, 32'h7FFF_FFFF, 32'd1);
        chk("R11 add overflow", {31'b0, vf}, 32'd1);
        apply(4'd0, 32'h1234_0000, 32'h0000_5678);
        chk("R11 add no overflow", {31'b0, vf}, 32'd0);
        chk("R1 add no carry", {31'b0, cf}, 32'd0);
    endtask

    task automatic t_sub;
        run_op("R2 sub", 4'd1, 32'd100, 32'd58);
        apply(4'd1, 32'd5, 32'd9);
        chk("R2 sub borrow result", res, 32'hFFFF_FFFC);
        chk("R2 sub borrow carry", {31'b0, cf}, 32'd0);
        apply(4'd1, 32'd9, 32'd9);
        chk("R2 sub equal carry", {31'b0, cf}, 32'd1);
        chk("R10 sub equal zero", {31'b0, zf}, 32'd1);
        apply(4'd1, 32'h8000_0000, 32'd1);
        chk("R2 sub overflow", {31'b0, vf}, 32'd1);
    endtask

    task automatic t_bitwise;
        run_op("R3 and", 4'd2, 32'hF0F0_1234, 32'h0FF0_FF00);
        run_op("R3 or", 4'd3, 32'hF0F0_1234, 32'h0FF0_FF00);
        run_op("R3 xor", 4'd4, 32'hF0F0_1234, 32'h0FF0_FF00);
        run_op("R3 xor self", 4'd4, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    endtask

    task automatic t_compare;
        run_op("R4 slt neg<pos", 4'd5, 32'hFFFF_FFFF, 32'd1);
        run_op("R4 slt pos<neg", 4'd5, 32'd1, 32'hFFFF_FFFF);
        run_op("R4 slt min<max", 4'd5, 32'h8000_0000, 32'h7FFF_FFFF);
        run_op("R4 slt equal", 4'd5, 32'd7, 32'd7);
        run_op("R5 sltu big<small", 4'd6, 32'hFFFF_FFFF, 32'd1);
        run_op("R5 sltu small<big", 4'd6, 32'd1, 32'hFFFF_FFFF);
        run_op("R5 sltu equal", 4'd6, 32'd0, 32'd0);
    endtask

    task automatic t_shift;
        run_op("R6 sll", 4'd7, 32'h0000_00F1, 32'd4);
        run_op("R6 sll max", 4'd7, 32'h0000_0003, 32'd31);
        apply(4'd7, 32'h0000_0001, 32'hFFFF_FFE3);
        chk("R6 sll upper b ignored", res, 32'h0000_0008);
        run_op("R7 srl", 4'd8, 32'h8000_0F00, 32'd8);
        run_op("R7 srl zero amount", 4'd8, 32'h8000_0F00, 32'd0);
        run_op("R8 sra neg", 4'd9, 32'h8000_0F00, 32'd8);
        run_op("R8 sra max", 4'd9, 32'h8000_0000, 32'd31);
        run_op("R8 sra pos", 4'd9, 32'h4000_0000, 32'd30);
    endtask

    task automatic t_unused;
        for (int c = 10; c < 16; c++) begin
            apply(c[3:0], 32'hFFFF_FFFF, 32'h1234_5678);
            chk("R9 unused code", res, 32'd0);
        end
    endtask

    task automatic t_narrow_sweep;
        int bad = 0;
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [7:0] xa, yb, d;
                logic       exp_c, exp_v;
                xa = x[7:0]; yb = y[7:0];
                d = xa - yb;
                exp_c = (x >= y);
                exp_v = (xa[7] != yb[7]) && (d[7] != xa[7]);
                na = xa; nb = yb;
                nop = 4'd1; #1;
                checks++;
                if (nres !== d || ncf !== exp_c || nvf !== exp_v) begin
                    errors++; bad++;
                    if (bad < 8) $display("FAIL R2 narrow sub a=%0d b=%0d actual=%h/%b/%b expected=%h/%b/%b",
                                          x, y, nres, ncf, nvf, d, exp_c, exp_v);
                end
                nop = 4'd5; #1;
                checks++;
                if (nres !== {7'b0, ($signed(xa) < $signed(yb))}) begin
                    errors++; bad++;
                    if (bad < 8) $display("FAIL R4 narrow slt a=%0d b=%0d actual=%h expected=%h",
                                          x, y, nres, {7'b0, ($signed(xa) < $signed(yb))});
                end
                nop = 4'd6; #1;
                checks++;
                if (nres !== {7'b0, (x < y)}) begin
                    errors++; bad++;
                    if (bad < 8) $display("FAIL R5 narrow sltu a=%0d b=%0d actual=%h expected=%h",
                                          x, y, nres, {7'b0, (x < y)});
                end
            end
        end
    endtask

    initial begin
        a = '0; b = '0; op = '0;
        na = '0; nb = '0; nop = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_add();
        t_sub();
        t_bitwise();
        t_compare();
        t_shift();
        t_unused();
        t_narrow_sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule